// File: doc/BRIEF.md
# Gated Edge-Triggered Pulse Generator

This block turns four loosely timed, asynchronous front-end signals into one clean, fixed-width, active-low output pulse. Two of the inputs are start indicators. The block opens a capture window only while the two start indicators disagree. The other two inputs are active-low detect lines. Once the window opens, the block ignores the detect lines for a settling interval so that glitches and slow edges cannot fire it. After that interval, a falling edge on either detect line fires the output pulse, as long as the window is still open.

All inputs are brought into the system clock domain through flop synchronisers before they are compared or edge-detected. The settling interval and the pulse width are parameters expressed in clock cycles. A pulse that has started always runs to its full width. Further edges do not stretch it or retrigger it. When the start indicators agree again, the window closes. The next window then goes through the whole settling interval again.

Top module: `gated_pulse_gen`

## Requirements
- R1: While `rst` is high at a clock edge, and in the cycle after it, `pulse_n` is 1 and the block is idle. This also holds when reset arrives in the middle of a pulse.
- R2: While the synchronised start inputs are equal, falling edges on the detect lines never produce a pulse.
- R3: A new mismatch between the start inputs starts a settling interval of `SETTLE_CYC` cycles. A detect falling edge applied before clock edge k, where the mismatch was applied before edge 0, is discarded when k <= `SETTLE_CYC`. It is not stored for later.
- R4: When the mismatch was applied before edge 0 and a falling edge on `det_a_n` or `det_b_n` is applied before edge k, with k >= `SETTLE_CYC`+1 and the window still open, `pulse_n` goes to 0 after edge k+2. The two synchroniser stages and one edge-detect stage account for this delay.
- R5: Each pulse holds `pulse_n` at 0 for exactly `PULSE_CYC` consecutive cycles.
- R6: A falling edge that arrives while a pulse is being driven neither lengthens that pulse nor starts a second one. Such edges include one on the other detect line and one that lands in the last low cycle.
- R7: Between two pulses, `pulse_n` is 1 for at least one cycle. An edge timed so that its pulse would start right after the previous one ends produces a second pulse after exactly one high cycle.
- R8: If the start inputs become equal while a pulse is in progress, the pulse still lasts the full `PULSE_CYC` cycles.
- R9: Once the start inputs have become equal, the window is closed. Reopening it requires a fresh full settling interval, measured from the new mismatch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_a | input | 1 | Start indicator A (asynchronous) |
| start_b | input | 1 | Start indicator B (asynchronous) |
| det_a_n | input | 1 | Detect line A, active low (asynchronous) |
| det_b_n | input | 1 | Detect line B, active low (asynchronous) |
| pulse_n | output | 1 | Active-low output pulse |

## Verification
The bench builds the block with `SETTLE_CYC` = 3 and `PULSE_CYC` = 5. These short settings keep every scenario brief, so the bench can sweep the detect edge across every cycle offset from the window opening to well past arming. It does this for both detect lines and both mismatch polarities. With these settings, the exact boundary between discarded and accepted edges is exercised. So are the pulse-end cycle, where a second edge is just refused or just accepted, and the case where the window closes mid-pulse. The expected latency, width and pulse count for each case are worked out from the offsets.

// File: rtl/gpg_pkg.sv
package gpg_pkg;

    typedef enum logic [1:0] {
        W_IDLE   = 2'd0,
        W_SETTLE = 2'd1,
        W_ARMED  = 2'd2
    } win_state_e;

endpackage

// File: rtl/gpg_sync.sv
module gpg_sync #(
    parameter int              WIDTH     = 4,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                assign chain_d[g] = din;
            end else begin : g_next
                assign chain_d[g] = chain_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= RESET_VAL;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/gpg_window.sv
module gpg_window
    import gpg_pkg::*;
#(
    parameter int SETTLE_CYC = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic differ,
    output logic armed
);

    localparam int CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);

    typedef struct packed {
        win_state_e      st;
        logic [CW-1:0]   cnt;
    } win_regs_t;

    win_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            W_IDLE: begin
                if (differ) begin
                    r_d.st  = W_SETTLE;
                    r_d.cnt = '0;
                end
            end
            W_SETTLE: begin
                if (!differ) begin
                    r_d.st = W_IDLE;
                end else if (r_q.cnt == CW'(SETTLE_CYC - 1)) begin
                    r_d.st = W_ARMED;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            W_ARMED: begin
                if (!differ) r_d.st = W_IDLE;
            end
            default: r_d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st  <= W_IDLE;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign armed = (r_q.st == W_ARMED);

endmodule

// File: rtl/gpg_pulse.sv
module gpg_pulse #(
    parameter int PULSE_CYC = 75
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic pulse_n
);

    localparam int PW = (PULSE_CYC < 2) ? 1 : $clog2(PULSE_CYC);

    typedef struct packed {
        logic          low;
        logic [PW-1:0] left;
    } pulse_regs_t;

    pulse_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (r_q.low) begin
            if (r_q.left == '0) r_d.low  = 1'b0;
            else                r_d.left = r_q.left - 1'b1;
        end else if (trig) begin
            r_d.low  = 1'b1;
            r_d.left = PW'(PULSE_CYC - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.low  <= 1'b0;
            r_q.left <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pulse_n = ~r_q.low;

endmodule

// File: rtl/gated_pulse_gen.sv
module gated_pulse_gen #(
    parameter int SETTLE_CYC  = 10,
    parameter int PULSE_CYC   = 75,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start_a,
    input  logic start_b,
    input  logic det_a_n,
    input  logic det_b_n,
    output logic pulse_n
);

    localparam int NUM_IN = 4;
    localparam logic [NUM_IN-1:0] IN_IDLE = 4'b1100;

    typedef struct packed {
        logic [1:0] det_prev;
    } edge_regs_t;

    logic [NUM_IN-1:0] raw_in, sync_in;
    logic              sync_differ;
    logic              win_armed;
    logic [1:0]        det_now;
    logic [1:0]        det_fall;
    logic              fire;
    edge_regs_t        e_d, e_q;

    assign raw_in = {det_b_n, det_a_n, start_b, start_a};

    gpg_sync #(
        .WIDTH    (NUM_IN),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(IN_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din (raw_in),
        .dout(sync_in)
    );

    assign sync_differ = sync_in[0] ^ sync_in[1];
    assign det_now     = sync_in[3:2];

    gpg_window #(
        .SETTLE_CYC(SETTLE_CYC)
    ) u_window (
        .clk   (clk),
        .rst   (rst),
        .differ(sync_differ),
        .armed (win_armed)
    );

    always_comb begin
        e_d          = e_q;
        e_d.det_prev = det_now;
        det_fall     = e_q.det_prev & ~det_now;
        fire         = win_armed & sync_differ & (|det_fall);
    end

    always_ff @(posedge clk) begin
        if (rst) e_q.det_prev <= 2'b11;
        else     e_q <= e_d;
    end

    gpg_pulse #(
        .PULSE_CYC(PULSE_CYC)
    ) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .trig   (fire),
        .pulse_n(pulse_n)
    );

endmodule

// File: rtl/gpg_checker.sv
module gpg_checker #(
    parameter int PULSE_CYC = 75
) (
    input logic clk,
    input logic rst,
    input logic pulse_n,
    input logic armed,
    input logic differ
);

    localparam int RW = $clog2(PULSE_CYC + 2);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)                          run_q <= '0;
        else if (pulse_n)                 run_q <= '0;
        else if (run_q != RW'(PULSE_CYC + 1)) run_q <= run_q + 1'b1;
    end

    AST_RESET_HIGH: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> pulse_n);                                           // R1
    AST_NO_PULSE_EQUAL: assert property (@(posedge clk) disable iff (rst)
        $fell(pulse_n) |-> $past(differ));                                 // R2
    AST_ONLY_WHEN_ARMED: assert property (@(posedge clk) disable iff (rst)
        $fell(pulse_n) |-> $past(armed));                                  // R3
    AST_FULL_WIDTH: assert property (@(posedge clk) disable iff (rst)
        (!pulse_n && (run_q < RW'(PULSE_CYC - 1))) |=> !pulse_n);          // R5
    AST_NO_STRETCH: assert property (@(posedge clk) disable iff (rst)
        !pulse_n |-> (run_q < RW'(PULSE_CYC)));                            // R6

endmodule

bind gated_pulse_gen gpg_checker #(.PULSE_CYC(PULSE_CYC)) u_gpg_checker (
    .clk    (clk),
    .rst    (rst),
    .pulse_n(pulse_n),
    .armed  (win_armed),
    .differ (sync_differ)
);

// File: tb/test_gated_pulse_gen.sv
module test_gated_pulse_gen;

    localparam int S   = 3;
    localparam int P   = 5;
    localparam int HOR = 2 * S + 2 * P + 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sa = 1'b0, sb = 1'b0, da = 1'b1, db = 1'b1;
    logic pulse_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    gated_pulse_gen #(
        .SETTLE_CYC (S),
        .PULSE_CYC  (P),
        .SYNC_STAGES(2)
    ) i_gated_pulse_gen (
        .clk    (clk),
        .rst    (rst),
        .start_a(sa),
        .start_b(sb),
        .det_a_n(da),
        .det_b_n(db),
        .pulse_n(pulse_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Inputs change at the negedge before the edge with the same index; samples are
    // taken at the negedge after each edge.
    task automatic scenario(input int open_j, input logic va, input logic vb,
                            input int close_j, input int reopen_j,
                            input int ea, input int eb,
                            output int first, output int total, output int runs);
        bit prev_high = 1'b1;
        first = -1; total = 0; runs = 0;
        for (int j = 0; j < HOR; j++) begin
            if (j == open_j)   begin sa = va;   sb = vb;   end
            if (j == close_j)  begin sa = 1'b0; sb = 1'b0; end
            if (j == reopen_j) begin sa = va;   sb = vb;   end
            if (j == ea) da = 1'b0;
            if (j == eb) db = 1'b0;
            @(posedge clk);
            @(negedge clk);
            if (!pulse_n) begin
                total++;
                if (first < 0) first = j;
                if (prev_high) runs++;
            end
            prev_high = pulse_n;
        end
        sa = 1'b0; sb = 1'b0; da = 1'b1; db = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic expect_one(input string req, input int first, input int total,
                              input int runs, input int exp_first);
        chk(first == exp_first, req, "first low cycle", first, exp_first);
        chk(total == ((exp_first < 0) ? 0 : P), "R5", "low cycles", total,
            (exp_first < 0) ? 0 : P);
        chk(runs == ((exp_first < 0) ? 0 : 1), "R6", "pulse count", runs,
            (exp_first < 0) ? 0 : 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int f, t, r, exp_f;
        repeat (4) @(negedge clk);
        chk(pulse_n == 1'b1, "R1", "pulse_n in reset", int'(pulse_n), 1);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(pulse_n == 1'b1, "R1", "pulse_n after reset", int'(pulse_n), 1);

        // R3 / R4 sweep: edge offset, detect line, mismatch polarity
        for (int pol = 0; pol < 2; pol++) begin
            for (int line = 0; line < 2; line++) begin
                for (int d = 0; d <= S + 3; d++) begin
                    exp_f = (d >= S + 1) ? d + 2 : -1;
                    scenario(0, logic'(pol), logic'(1 - pol), -1, -1,
                             (line == 0) ? d : -1, (line == 1) ? d : -1, f, t, r);
                    expect_one((d >= S + 1) ? "R4" : "R3", f, t, r, exp_f);
                end
            end
        end

        // R2: starts equal (both high, then both low)
        scenario(0, 1'b1, 1'b1, -1, -1, S + 2, S + 4, f, t, r);
        expect_one("R2", f, t, r, -1);
        scenario(0, 1'b0, 1'b0, -1, -1, 1, S + 5, f, t, r);
        expect_one("R2", f, t, r, -1);

        // R6: second edge on the other line during the pulse
        scenario(0, 1'b1, 1'b0, -1, -1, S + 1, S + 3, f, t, r);
        expect_one("R6", f, t, r, S + 3);
        // R6: both lines fall together
        scenario(0, 1'b0, 1'b1, -1, -1, S + 2, S + 2, f, t, r);
        expect_one("R6", f, t, r, S + 4);
        // R6: edge landing in the last low cycle is discarded
        scenario(0, 1'b1, 1'b0, -1, -1, S + 1, S + 1 + P, f, t, r);
        expect_one("R6", f, t, r, S + 3);

        // R7: edge accepted right after the pulse ends, one high cycle between
        scenario(0, 1'b1, 1'b0, -1, -1, S + 1, S + 2 + P, f, t, r);
        chk(r == 2, "R7", "pulse count", r, 2);
        chk(t == 2 * P, "R7", "low cycles", t, 2 * P);
        chk(f == S + 3, "R7", "first low cycle", f, S + 3);

        // R8: window closes during the pulse
        scenario(0, 1'b0, 1'b1, S + 4, -1, S + 1, -1, f, t, r);
        expect_one("R8", f, t, r, S + 3);

        // R9: close, reopen, edge just inside new settle interval -> dropped
        scenario(0, 1'b1, 1'b0, S + 5, S + 10, S + 10 + S, -1, f, t, r);
        expect_one("R9", f, t, r, -1);
        // R9: edge at first accepted offset after reopen
        scenario(0, 1'b1, 1'b0, S + 5, S + 10, -1, S + 10 + S + 1, f, t, r);
        expect_one("R9", f, t, r, S + 10 + S + 3);

        // R1: reset in the middle of a pulse
        sa = 1'b1; sb = 1'b0;
        repeat (S + 2) @(negedge clk);
        da = 1'b0;
        repeat (4) @(negedge clk);
        chk(pulse_n == 1'b0, "R1", "pulse started before reset", int'(pulse_n), 0);
        rst = 1'b1;
        @(negedge clk);
        chk(pulse_n == 1'b1, "R1", "pulse_n after mid-pulse reset", int'(pulse_n), 1);
        sa = 1'b0; da = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (P + 4) @(negedge clk);
        chk(pulse_n == 1'b1, "R1", "idle after reset release", int'(pulse_n), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule